// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is an on-chip RAM with one port that only writes and one port that only reads, both usable in the same cycle at different locations. The two ports may have different data widths. Both see one storage array of `TOTAL_BITS` bits. The narrow port's address therefore picks a sub-word inside one word of the wide port, and sub-word 0 sits at the least significant end of the wide word. The two widths must belong to the same family: both free of the ninth bit (1, 2, 4, 8, 16, 32 ...), or both multiples of 9 (9, 18, 36). For example, a 9216-bit array can be shaped as 1K×9, 512×18 or 256×36.

Each port has a clock enable and an address stall input. While the stall input is high, the port keeps using the address it last latched. The read side runs on the write clock when `SEP_CLK` is 0 and on its own clock otherwise. `RDW_MODE` chooses what a shared-clock read returns when it hits the row being written in the same cycle: the old stored contents or an undefined value. An output latch always holds the read result, and `OUT_REG` can add a register after it. `aclr` clears only the latch, the register and the address latches, never the array.

Top module: `mixed_sdp_ram`

## Requirements
- R1: While `aclr` is high, `q` reads all zeros.
- R2: With an 8-bit write port and a 32-bit read port, wide row r holds narrow addresses 4r to 4r+3, with address 4r+k in bits [8k+7:8k]. A read of row r returns that concatenation.
- R3: A read fires on the clock edge where `rd_ce` and `rd_en` are both high. With `OUT_REG`=0 its data is on `q` right after that edge. With `OUT_REG`=1 it appears one edge later, and `q` keeps its previous value until then.
- R4: While `rd_en` is low and `rd_ce` is high, the output latch holds the most recent read result.
- R5: While `rd_ce` is low, `q` does not change. While `wr_ce` is low, `wr_en` writes nothing.
- R6: While `wr_stall` is high, a write goes to the address latched on the last clock-enabled edge with `wr_stall` low, and `wr_addr` is ignored.
- R7: While `rd_stall` is high, a read uses the address latched on the last clock-enabled edge with `rd_stall` low.
- R8: With a shared clock and `RDW_MODE` set to old data, a read of the row being written in the same cycle returns the contents from before the write.
- R9: Pulsing `aclr` leaves the array contents intact. A later read returns the data written before the clear.
- R10: A write and a read to different locations in the same cycle both take effect.
- R11: With a 36-bit write port and a 9-bit read port, narrow read address 4r+k returns bits [9k+8:9k] of the wide word written at row r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; also the read clock when SEP_CLK is 0 |
| rd_clk | input | 1 | Read clock, used only when SEP_CLK is 1 |
| aclr | input | 1 | Asynchronous clear of output latch, output register and address latches |
| wr_ce | input | 1 | Write-side clock enable |
| wr_en | input | 1 | Write request |
| wr_stall | input | 1 | Hold the previously latched write address |
| wr_addr | input | WR_AW | Write address, in units of WR_W bits |
| wr_data | input | WR_W | Write data |
| rd_ce | input | 1 | Read-side clock enable |
| rd_en | input | 1 | Read request |
| rd_stall | input | 1 | Hold the previously latched read address |
| rd_addr | input | RD_AW | Read address, in units of RD_W bits |
| q | output | RD_W | Read data |

## Verification
The width conversion is tested in both directions. A narrow-write, wide-read instance is fed byte writes to every lane of several rows, including the highest row, and then read back whole words. This shows whether lane order and row selection are right. A wide-write, narrow-read instance is read at every sub-word of a row. This separates a correct least-significant-first placement from a reversed or shifted one. Same-row write-and-read pairs check the old-data choice, and different-row pairs check that both operations complete. Stall, enable and clear sequences are chosen so that a held and a fresh address or value give different data.

// File: rtl/msdp_pkg.sv
package msdp_pkg;

    typedef enum logic {
        RDW_OLD      = 1'b0,
        RDW_DONTCARE = 1'b1
    } rdw_mode_e;

    function automatic int unsigned addr_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/msdp_addr_hold.sv
module msdp_addr_hold #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          aclr,
    input  logic          ce,
    input  logic          stall,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff,
    output logic [AW-1:0] addr_held
);

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            addr_held <= '0;
        end else if (ce && !stall) begin
            addr_held <= addr_in;
        end
    end

    // A stalled port works on the held address; otherwise the new one.
    assign addr_eff = stall ? addr_held : addr_in;

endmodule

// File: rtl/msdp_lane_bank.sv
module msdp_lane_bank #(
    parameter int unsigned ROWS   = 256,
    parameter int unsigned W      = 8,
    parameter int unsigned ROW_AW = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ROW_AW-1:0] wrow,
    input  logic [W-1:0]      wdata,
    input  logic [ROW_AW-1:0] rrow,
    output logic [W-1:0]      rdata
);

    logic [W-1:0] mem [ROWS];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[wrow] <= wdata;
        end
    end

    // Combinational view; the read stage samples it before this edge's write lands.
    assign rdata = mem[rrow];

endmodule

// File: rtl/msdp_read_stage.sv
module msdp_read_stage #(
    parameter int unsigned W       = 32,
    parameter bit          OUT_REG = 1'b1,
    parameter bit          DC      = 1'b0
) (
    input  logic         clk,
    input  logic         aclr,
    input  logic         ce,
    input  logic         en,
    input  logic         coll,
    input  logic [W-1:0] din,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            latch_q <= '0;
        end else if (ce && en) begin
            latch_q <= (DC && coll) ? {W{1'bx}} : din;
        end
    end

    generate
        if (OUT_REG) begin : g_oreg
            logic [W-1:0] oreg;
            always_ff @(posedge clk or posedge aclr) begin
                if (aclr) begin
                    oreg <= '0;
                end else if (ce) begin
                    oreg <= latch_q;
                end
            end
            assign q = oreg;
        end else begin : g_flow
            assign q = latch_q;
        end
    endgenerate

endmodule

// File: rtl/mixed_sdp_ram.sv
module mixed_sdp_ram
    import msdp_pkg::*;
#(
    parameter int unsigned TOTAL_BITS = 8192,
    parameter int unsigned WR_W       = 8,
    parameter int unsigned RD_W       = 32,
    parameter bit          SEP_CLK    = 1'b0,
    parameter bit          OUT_REG    = 1'b1,
    parameter rdw_mode_e   RDW_MODE   = RDW_OLD,
    localparam int unsigned WR_AW     = addr_bits(TOTAL_BITS / WR_W),
    localparam int unsigned RD_AW     = addr_bits(TOTAL_BITS / RD_W)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             aclr,
    input  logic             wr_ce,
    input  logic             wr_en,
    input  logic             wr_stall,
    input  logic [WR_AW-1:0] wr_addr,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             rd_ce,
    input  logic             rd_en,
    input  logic             rd_stall,
    input  logic [RD_AW-1:0] rd_addr,
    output logic [RD_W-1:0]  q
);

    localparam int unsigned WIDE_W    = (WR_W > RD_W) ? WR_W : RD_W;
    localparam int unsigned UNIT_W    = (WR_W > RD_W) ? RD_W : WR_W;
    localparam int unsigned LANES     = WIDE_W / UNIT_W;
    localparam int unsigned ROWS      = TOTAL_BITS / WIDE_W;
    localparam int unsigned ROW_AW    = addr_bits(ROWS);
    localparam int unsigned WR_LANES  = WR_W / UNIT_W;
    localparam int unsigned RD_LANES  = RD_W / UNIT_W;
    localparam int unsigned WR_GROUPS = WIDE_W / WR_W;
    localparam int unsigned RD_GROUPS = WIDE_W / RD_W;
    localparam int unsigned WR_SH     = $clog2(WR_GROUPS);
    localparam int unsigned RD_SH     = $clog2(RD_GROUPS);
    localparam int unsigned WR_GW     = addr_bits(WR_GROUPS);
    localparam int unsigned RD_GW     = addr_bits(RD_GROUPS);
    localparam bit          DC        = (RDW_MODE == RDW_DONTCARE);

    logic              rclk;
    logic [WR_AW-1:0]  wr_eff;
    logic [WR_AW-1:0]  wr_held;
    logic [RD_AW-1:0]  rd_eff;
    logic [RD_AW-1:0]  rd_held;
    logic [ROW_AW-1:0] wr_row;
    logic [ROW_AW-1:0] rd_row;
    logic [WR_GW-1:0]  wr_grp;
    logic [RD_GW-1:0]  rd_grp;
    logic              wr_fire;
    logic              rd_fire;
    logic              coll;
    logic [UNIT_W-1:0] lane_q [LANES];
    logic [RD_W-1:0]   rd_comb;
    logic [RD_W-1:0]   rd_word;

    // Read side runs on the write clock unless a separate read clock is chosen.
    assign rclk = SEP_CLK ? rd_clk : wr_clk;

    msdp_addr_hold #(.AW(WR_AW)) u_wr_hold (
        .clk       (wr_clk),
        .aclr      (aclr),
        .ce        (wr_ce),
        .stall     (wr_stall),
        .addr_in   (wr_addr),
        .addr_eff  (wr_eff),
        .addr_held (wr_held)
    );

    msdp_addr_hold #(.AW(RD_AW)) u_rd_hold (
        .clk       (rclk),
        .aclr      (aclr),
        .ce        (rd_ce),
        .stall     (rd_stall),
        .addr_in   (rd_addr),
        .addr_eff  (rd_eff),
        .addr_held (rd_held)
    );

    // Narrow address = {row, sub-word}; sub-word 0 is the least significant lane group.
    assign wr_row  = ROW_AW'(wr_eff >> WR_SH);
    assign rd_row  = ROW_AW'(rd_eff >> RD_SH);
    assign wr_grp  = WR_GW'(wr_eff & WR_AW'(WR_GROUPS - 1));
    assign rd_grp  = RD_GW'(rd_eff & RD_AW'(RD_GROUPS - 1));
    assign wr_fire = wr_ce && wr_en;
    assign rd_fire = rd_ce && rd_en;

    // One of the ports always spans the full row, so a shared row means overlapping bits.
    assign coll = !SEP_CLK && wr_fire && rd_fire && (wr_row == rd_row);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int unsigned LG = l / WR_LANES;
            localparam int unsigned LS = l % WR_LANES;
            logic lane_we;
            assign lane_we = wr_fire && (wr_grp == WR_GW'(LG));
            msdp_lane_bank #(
                .ROWS   (ROWS),
                .W      (UNIT_W),
                .ROW_AW (ROW_AW)
            ) u_bank (
                .wclk  (wr_clk),
                .we    (lane_we),
                .wrow  (wr_row),
                .wdata (wr_data[LS*UNIT_W +: UNIT_W]),
                .rrow  (rd_row),
                .rdata (lane_q[l])
            );
        end
    endgenerate

    always_comb begin
        for (int j = 0; j < RD_LANES; j++) begin
            rd_comb[j*UNIT_W +: UNIT_W] = lane_q[int'(rd_grp) * RD_LANES + j];
        end
    end

    msdp_read_stage #(
        .W       (RD_W),
        .OUT_REG (OUT_REG),
        .DC      (DC)
    ) u_rd_stage (
        .clk     (rclk),
        .aclr    (aclr),
        .ce      (rd_ce),
        .en      (rd_en),
        .coll    (coll),
        .din     (rd_comb),
        .latch_q (rd_word),
        .q       (q)
    );

endmodule

// File: rtl/msdp_checker.sv
module msdp_checker #(
    parameter int unsigned WAW = 10,
    parameter int unsigned RAW = 8,
    parameter int unsigned QW  = 32
) (
    input logic           wr_clk,
    input logic           rclk,
    input logic           aclr,
    input logic           wr_stall,
    input logic           rd_ce,
    input logic           rd_en,
    input logic           rd_stall,
    input logic [WAW-1:0] wr_hold,
    input logic [RAW-1:0] rd_hold,
    input logic [QW-1:0]  rd_word,
    input logic [QW-1:0]  q
);

    assert_clear_R1: assert property (@(posedge rclk)
        aclr |-> (q == '0))
        else $error("R1: q not cleared during aclr");

    assert_en_hold_R4: assert property (@(posedge rclk) disable iff (aclr)
        (rd_ce && !rd_en) |=> $stable(rd_word))
        else $error("R4: output latch moved without a read");

    assert_ce_hold_R5: assert property (@(posedge rclk) disable iff (aclr)
        !rd_ce |=> $stable(q))
        else $error("R5: q moved with read clock enable low");

    assert_wr_stall_R6: assert property (@(posedge wr_clk) disable iff (aclr)
        wr_stall |=> $stable(wr_hold))
        else $error("R6: write address latch moved while stalled");

    assert_rd_stall_R7: assert property (@(posedge rclk) disable iff (aclr)
        rd_stall |=> $stable(rd_hold))
        else $error("R7: read address latch moved while stalled");

endmodule

bind mixed_sdp_ram msdp_checker #(
    .WAW (WR_AW),
    .RAW (RD_AW),
    .QW  (RD_W)
) u_msdp_chk (
    .wr_clk   (wr_clk),
    .rclk     (rclk),
    .aclr     (aclr),
    .wr_stall (wr_stall),
    .rd_ce    (rd_ce),
    .rd_en    (rd_en),
    .rd_stall (rd_stall),
    .wr_hold  (wr_held),
    .rd_hold  (rd_held),
    .rd_word  (rd_word),
    .q        (q)
);

// File: tb/test_mixed_sdp_ram.sv
module test_mixed_sdp_ram;
    import msdp_pkg::*;

    logic clk = 1'b0;
    logic aclr = 1'b1;
    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;

    // Instance A: 8-bit write, 32-bit read, registered output.
    logic        a_wce, a_wen, a_wst, a_rce, a_ren, a_rst;
    logic [9:0]  a_wa;
    logic [7:0]  a_wd;
    logic [7:0]  a_ra;
    logic [31:0] a_q;

    mixed_sdp_ram #(
        .TOTAL_BITS (8192), .WR_W (8), .RD_W (32),
        .SEP_CLK (1'b0), .OUT_REG (1'b1), .RDW_MODE (RDW_OLD)
    ) i_mixed_sdp_ram (
        .wr_clk (clk), .rd_clk (clk), .aclr (aclr),
        .wr_ce (a_wce), .wr_en (a_wen), .wr_stall (a_wst),
        .wr_addr (a_wa), .wr_data (a_wd),
        .rd_ce (a_rce), .rd_en (a_ren), .rd_stall (a_rst),
        .rd_addr (a_ra), .q (a_q)
    );

    // Instance B: 36-bit write, 9-bit read, flow-through output.
    logic        b_wce, b_wen, b_wst, b_rce, b_ren, b_rst;
    logic [7:0]  b_wa;
    logic [35:0] b_wd;
    logic [9:0]  b_ra;
    logic [8:0]  b_q;

    mixed_sdp_ram #(
        .TOTAL_BITS (9216), .WR_W (36), .RD_W (9),
        .SEP_CLK (1'b0), .OUT_REG (1'b0), .RDW_MODE (RDW_OLD)
    ) i_mixed_sdp_ram_b (
        .wr_clk (clk), .rd_clk (clk), .aclr (aclr),
        .wr_ce (b_wce), .wr_en (b_wen), .wr_stall (b_wst),
        .wr_addr (b_wa), .wr_data (b_wd),
        .rd_ce (b_rce), .rd_en (b_ren), .rd_stall (b_rst),
        .rd_addr (b_ra), .q (b_q)
    );

    logic [7:0]  mA [1024];
    logic [35:0] mB [256];

    // {we, waddr[9:0], wdata[7:0], re, raddr[7:0]}
    localparam logic [27:0] VEC [15] = '{
        {1'b1, 10'd0,    8'hEE, 1'b1, 8'd0},    // R8 same row, old data
        {1'b0, 10'd0,    8'h00, 1'b1, 8'd0},    // R2 new lane 0
        {1'b1, 10'd5,    8'h5A, 1'b1, 8'd2},    // R10 different rows
        {1'b0, 10'd0,    8'h00, 1'b1, 8'd1},
        {1'b1, 10'd62,   8'hC3, 1'b1, 8'd15},   // R8 lane 2 of row 15
        {1'b1, 10'd63,   8'h3C, 1'b0, 8'd0},
        {1'b0, 10'd0,    8'h00, 1'b1, 8'd15},
        {1'b1, 10'd12,   8'h81, 1'b1, 8'd4},    // R10
        {1'b1, 10'd13,   8'h82, 1'b1, 8'd3},    // R8
        {1'b0, 10'd0,    8'h00, 1'b1, 8'd3},
        {1'b1, 10'd1020, 8'hA1, 1'b0, 8'd0},
        {1'b1, 10'd1021, 8'hB2, 1'b0, 8'd0},
        {1'b1, 10'd1022, 8'hC3, 1'b0, 8'd0},
        {1'b1, 10'd1023, 8'hD4, 1'b1, 8'd14},
        {1'b0, 10'd0,    8'h00, 1'b1, 8'd255}   // R2 top row
    };

    function automatic logic [31:0] rowA(input int r);
        return {mA[4*r+3], mA[4*r+2], mA[4*r+1], mA[4*r]};
    endfunction

    function automatic logic [8:0] subB(input int a);
        logic [35:0] w;
        w = mB[a/4];
        return w[9*(a%4) +: 9];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge act, then go idle.
    task automatic driveA(input logic we, input logic [9:0] wa, input logic [7:0] wd,
                          input logic re, input logic [7:0] ra);
        a_wen = we; a_wa = wa; a_wd = wd; a_ren = re; a_ra = ra;
        @(negedge clk);
        a_wen = 1'b0; a_ren = 1'b0;
    endtask

    task automatic driveB(input logic we, input logic [7:0] wa, input logic [35:0] wd,
                          input logic re, input logic [9:0] ra);
        b_wen = we; b_wa = wa; b_wd = wd; b_ren = re; b_ra = ra;
        @(negedge clk);
        b_wen = 1'b0; b_ren = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] exp;
        a_wce = 1; a_wen = 0; a_wst = 0; a_rce = 1; a_ren = 0; a_rst = 0;
        a_wa = '0; a_wd = '0; a_ra = '0;
        b_wce = 1; b_wen = 0; b_wst = 0; b_rce = 1; b_ren = 0; b_rst = 0;
        b_wa = '0; b_wd = '0; b_ra = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset A", 64'(a_q), 64'h0);
        chk("R1 reset B", 64'(b_q), 64'h0);
        aclr = 1'b0;
        @(negedge clk);

        for (int a = 0; a < 64; a++) begin
            mA[a] = 8'(a * 7 + 3);
            driveA(1'b1, 10'(a), mA[a], 1'b0, 8'd0);
        end

        // R3: registered output appears one edge after the read edge.
        a_ren = 1'b1; a_ra = 8'd0;
        @(negedge clk);
        a_ren = 1'b0;
        chk("R3 not yet", 64'(a_q), 64'h0);
        @(negedge clk);
        chk("R3 registered read", 64'(a_q), 64'(rowA(0)));

        // Table walk: R2, R8, R10 against the byte model.
        for (int i = 0; i < 15; i++) begin
            logic [27:0] v;
            v = VEC[i];
            exp = rowA(int'(v[7:0]));
            if (v[27]) mA[v[26:17]] = v[16:9];
            driveA(v[27], v[26:17], v[16:9], v[8], v[7:0]);
            @(negedge clk);
            if (v[8]) chk($sformatf("R2 R8 R10 table entry %0d", i), 64'(a_q), 64'(exp));
        end

        // R4: rd_en low keeps the last result.
        driveA(1'b0, 10'd0, 8'd0, 1'b1, 8'd5);
        @(negedge clk);
        chk("R4 read row 5", 64'(a_q), 64'(rowA(5)));
        a_ra = 8'd6;
        repeat (3) @(negedge clk);
        chk("R4 hold with rd_en low", 64'(a_q), 64'(rowA(5)));

        // R5: read clock enable low freezes q.
        a_rce = 1'b0; a_ren = 1'b1; a_ra = 8'd7;
        repeat (3) @(negedge clk);
        chk("R5 hold with rd_ce low", 64'(a_q), 64'(rowA(5)));
        a_rce = 1'b1; a_ren = 1'b0;

        // R5: write clock enable low blocks the write.
        a_wce = 1'b0;
        driveA(1'b1, 10'd20, 8'hFF, 1'b0, 8'd0);
        a_wce = 1'b1;
        driveA(1'b0, 10'd0, 8'd0, 1'b1, 8'd5);
        @(negedge clk);
        chk("R5 write ignored with wr_ce low", 64'(a_q), 64'(rowA(5)));

        // R6: stalled write lands on the held address.
        mA[40] = 8'h01;
        driveA(1'b1, 10'd40, 8'h01, 1'b0, 8'd0);
        a_wst = 1'b1;
        mA[40] = 8'h02;
        driveA(1'b1, 10'd44, 8'h02, 1'b0, 8'd0);
        a_wst = 1'b0;
        driveA(1'b0, 10'd0, 8'd0, 1'b1, 8'd10);
        @(negedge clk);
        chk("R6 stalled write to held row", 64'(a_q), 64'(rowA(10)));
        driveA(1'b0, 10'd0, 8'd0, 1'b1, 8'd11);
        @(negedge clk);
        chk("R6 new address untouched", 64'(a_q), 64'(rowA(11)));

        // R7: stalled read uses the held address.
        driveA(1'b0, 10'd0, 8'd0, 1'b1, 8'd3);
        @(negedge clk);
        a_rst = 1'b1;
        driveA(1'b0, 10'd0, 8'd0, 1'b1, 8'd4);
        @(negedge clk);
        a_rst = 1'b0;
        chk("R7 stalled read", 64'(a_q), 64'(rowA(3)));

        // R9: clear hits the output only.
        aclr = 1'b1;
        @(negedge clk);
        chk("R1 R9 cleared output", 64'(a_q), 64'h0);
        aclr = 1'b0;
        @(negedge clk);
        driveA(1'b0, 10'd0, 8'd0, 1'b1, 8'd10);
        @(negedge clk);
        chk("R9 array kept", 64'(a_q), 64'(rowA(10)));

        // R11: wide writes read back per 9-bit sub-word (flow-through, R3).
        mB[5] = 36'hA_BCDE_F012;
        driveB(1'b1, 8'd5, mB[5], 1'b0, 10'd0);
        mB[6] = 36'h1_FF00_7E81;
        driveB(1'b1, 8'd6, mB[6], 1'b0, 10'd0);
        for (int k = 0; k < 4; k++) begin
            driveB(1'b0, 8'd0, 36'd0, 1'b1, 10'(20 + k));
            chk($sformatf("R11 R3 row 5 sub %0d", k), 64'(b_q), 64'(subB(20 + k)));
        end
        driveB(1'b0, 8'd0, 36'd0, 1'b1, 10'd24);
        chk("R11 row 6 sub 0", 64'(b_q), 64'(subB(24)));
        driveB(1'b0, 8'd0, 36'd0, 1'b1, 10'd27);
        chk("R11 row 6 sub 3", 64'(b_q), 64'(subB(27)));

        summary();
        $finish;
    end

endmodule